// File: doc/BRIEF.md
# EEPROM Byte and Burst Access Engine

This engine sits between a host register port and an external byte-wide EEPROM. The host can read or write one EEPROM byte at a time through a small register set. It can also start a burst read that walks a list of records stored in the EEPROM and copies their payload bytes into on-chip memory.

The EEPROM itself is reached through a byte request/acknowledge handshake; a serial physical layer would sit behind it. Burst payloads leave through a write-only memory port carrying a 24-bit address. The upper 9 bits of that address come from a host register and the lower 15 bits come from the record header.

Burst reads do not always begin at address zero. The engine keeps an EEPROM read pointer. The first burst after reset starts at 0. Every later burst continues from the byte after the last one the engine touched, whether that was a single access or a burst.

Top module: `eeprom_access_engine`

## Requirements
- R1: After reset every host register reads as 0, `eeReq` is low and `memWrEn` is low.
- R2: Writing the control register (offset 0) with bit 1 set reads the EEPROM byte at the address register (offset 1) into the data register (offset 2). Bit 1 reads back as 1 until the byte has arrived and then returns to 0 by itself.
- R3: Writing the control register with bit 0 set writes the data register byte to the EEPROM at the address register. Bit 0 clears itself when the EEPROM acknowledges. If both bits are written as 1, only the write is performed.
- R4: Control bit 2 is a read-only busy flag. It is 1 from the cycle after a request is accepted until the operation ends. While busy, host writes to any register are ignored, and at most one of the write, read and burst request bits is set.
- R5: Writing bit 0 of the burst register (offset 3) starts a burst. The bit reads as 1 during the burst and clears itself when the burst ends.
- R6: The first burst after reset, with no single access before it, fetches its first byte from EEPROM address 0.
- R7: Any later burst fetches its first byte from the address after the last EEPROM byte accessed. The pointer wraps from the top EEPROM address to 0.
- R8: A burst is a sequence of records. Each record is an address high byte, an address low byte, a count byte, and then that many payload bytes. A record whose count is 0 ends the burst.
- R9: Payload byte i of a record is written to memory address {base[8:0], (recordAddress + i)[14:0]}. Here base is the 9-bit register at offset 4, and bit 15 of the record address is ignored. Payload bytes are written in EEPROM order, and nothing is written to memory outside a burst.
- R10: `eeReq` stays high with a stable `eeAddr` until `eeAck` is seen. Each acknowledge completes exactly one byte transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 3 | Host register offset for reads and writes |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Host read data for `regAddr` (combinational) |
| eeReq | output | 1 | EEPROM byte request |
| eeWrite | output | 1 | 1 = byte write, 0 = byte read |
| eeAddr | output | EE_AW | EEPROM byte address |
| eeWrData | output | 8 | Byte to write |
| eeAck | input | 1 | One-cycle completion pulse from the EEPROM side |
| eeRdData | input | 8 | Byte read, valid with `eeAck` |
| memWrEn | output | 1 | On-chip memory write strobe |
| memAddr | output | 24 | On-chip memory byte address |
| memWrData | output | 8 | On-chip memory write byte |

## Verification
The bench builds the engine with an 8-bit EEPROM address (EE_AW = 8) and keeps the 9-bit base and 24-bit destination. The whole EEPROM then fits in a 256-byte model. This lets the read pointer be driven to the top address, so the wrap from 0xFF to 0x00 across a burst start and through a record can be checked. The default base and destination widths keep the 15-bit wrap of the record address, and the dropped address bit 15, in reach with real values.

// File: rtl/eeacc_pkg.sv
package eeacc_pkg;

  localparam logic [2:0] OFF_CTL   = 3'd0;
  localparam logic [2:0] OFF_ADDR  = 3'd1;
  localparam logic [2:0] OFF_DATA  = 3'd2;
  localparam logic [2:0] OFF_BURST = 3'd3;
  localparam logic [2:0] OFF_BASE  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SINGLE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_COUNT,
    ST_PAYLOAD
  } eeState_e;

  // strobes from control to datapath; the load/finish strobes fire only with eeAck
  typedef struct packed {
    logic reqOn;
    logic writeOp;
    logic useReg;
    logic finishSingle;
    logic loadHi;
    logic loadLo;
    logic loadCnt;
    logic putByte;
    logic finishBurst;
  } eeStrobe_t;

endpackage

// File: rtl/eeacc_ctrl.sv
module eeacc_ctrl
  import eeacc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       goWr,
  input  logic       goRd,
  input  logic       goBurst,
  input  logic       eeAck,
  input  logic [7:0] eeRdData,
  input  logic       lastByte,
  output eeStrobe_t  strb,
  output logic       active
);

  eeState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (goWr || goRd) nextState = ST_SINGLE;
        else if (goBurst) nextState = ST_ADDR_HI;
      end
      ST_SINGLE: begin
        strb.reqOn   = 1'b1;
        strb.useReg  = 1'b1;
        strb.writeOp = goWr;
        if (eeAck) begin
          strb.finishSingle = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_ADDR_HI: begin
        strb.reqOn = 1'b1;
        if (eeAck) begin
          strb.loadHi = 1'b1;
          nextState = ST_ADDR_LO;
        end
      end
      ST_ADDR_LO: begin
        strb.reqOn = 1'b1;
        if (eeAck) begin
          strb.loadLo = 1'b1;
          nextState = ST_COUNT;
        end
      end
      ST_COUNT: begin
        strb.reqOn = 1'b1;
        if (eeAck) begin
          if (eeRdData == 8'd0) begin
            strb.finishBurst = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strb.loadCnt = 1'b1;
            nextState = ST_PAYLOAD;
          end
        end
      end
      ST_PAYLOAD: begin
        strb.reqOn = 1'b1;
        if (eeAck) begin
          strb.putByte = 1'b1;
          if (lastByte) nextState = ST_ADDR_HI;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign active = (state != ST_IDLE);

  // a pending request must not drop before its acknowledge
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reqOn && !eeAck) |=> strb.reqOn);

  // a single access only runs while its request bit is still set in the datapath
  assert_single_owned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SINGLE) |-> (goWr || goRd));

  // payload states belong to a burst the host asked for
  assert_burst_owned_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAYLOAD) |-> goBurst);

endmodule

// File: rtl/eeacc_dp.sv
module eeacc_dp
  import eeacc_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int BASE_W = 9,
  parameter int DEST_W = 24,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [HOST_W-1:0] regWrData,
  output logic [HOST_W-1:0] regRdData,
  input  eeStrobe_t         strb,
  input  logic              active,
  output logic              goWr,
  output logic              goRd,
  output logic              goBurst,
  output logic              lastByte,
  output logic              eeReq,
  output logic              eeWrite,
  output logic [EE_AW-1:0]  eeAddr,
  output logic [7:0]        eeWrData,
  input  logic              eeAck,
  input  logic [7:0]        eeRdData,
  output logic              memWrEn,
  output logic [DEST_W-1:0] memAddr,
  output logic [7:0]        memWrData
);

  localparam int LOW_W = DEST_W - BASE_W;
  localparam int REC_W = 16;

  logic              ctlWr, ctlRd, burstBit;
  logic [EE_AW-1:0]  addrReg, eePtr;
  logic [7:0]        dataReg, recLeft;
  logic [BASE_W-1:0] baseReg;
  logic [REC_W-1:0]  recAddr;
  logic              busy, hostWr, stepPtr;

  assign busy    = active | ctlWr | ctlRd | burstBit;
  assign hostWr  = regWrEn & ~busy;
  assign stepPtr = strb.loadHi | strb.loadLo | strb.loadCnt | strb.putByte | strb.finishBurst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlWr    <= 1'b0;
      ctlRd    <= 1'b0;
      burstBit <= 1'b0;
      addrReg  <= '0;
      dataReg  <= '0;
      baseReg  <= '0;
      eePtr    <= '0;
      recAddr  <= '0;
      recLeft  <= '0;
    end else begin
      if (hostWr) begin
        unique case (regAddr)
          OFF_CTL: begin
            ctlWr <= regWrData[0];
            ctlRd <= regWrData[1] & ~regWrData[0];
          end
          OFF_ADDR:  addrReg  <= regWrData[EE_AW-1:0];
          OFF_DATA:  dataReg  <= regWrData[7:0];
          OFF_BURST: burstBit <= regWrData[0];
          OFF_BASE:  baseReg  <= regWrData[BASE_W-1:0];
          default: ;
        endcase
      end
      if (strb.finishSingle) begin
        ctlWr <= 1'b0;
        ctlRd <= 1'b0;
        if (!strb.writeOp) dataReg <= eeRdData;
        eePtr <= addrReg + EE_AW'(1);
      end
      if (stepPtr) eePtr <= eePtr + EE_AW'(1);
      if (strb.loadHi) recAddr[15:8] <= eeRdData;
      if (strb.loadLo) recAddr[7:0]  <= eeRdData;
      if (strb.loadCnt) recLeft <= eeRdData;
      if (strb.putByte) begin
        recAddr <= recAddr + REC_W'(1);
        recLeft <= recLeft - 8'd1;
      end
      if (strb.finishBurst) burstBit <= 1'b0;
    end
  end

  assign goWr     = ctlWr;
  assign goRd     = ctlRd;
  assign goBurst  = burstBit;
  assign lastByte = (recLeft == 8'd1);

  assign eeReq    = strb.reqOn;
  assign eeWrite  = strb.writeOp;
  assign eeAddr   = strb.useReg ? addrReg : eePtr;
  assign eeWrData = dataReg;

  assign memWrEn   = strb.putByte;
  assign memAddr   = {baseReg, recAddr[LOW_W-1:0]};
  assign memWrData = eeRdData;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      OFF_CTL: begin
        regRdData[0] = ctlWr;
        regRdData[1] = ctlRd;
        regRdData[2] = busy;
      end
      OFF_ADDR:  regRdData[EE_AW-1:0]  = addrReg;
      OFF_DATA:  regRdData[7:0]        = dataReg;
      OFF_BURST: regRdData[0]          = burstBit;
      OFF_BASE:  regRdData[BASE_W-1:0] = baseReg;
      default: ;
    endcase
  end

  assert_one_op_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctlWr, ctlRd, burstBit}));

  assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn) |=> ($stable(addrReg) && $stable(baseReg)));

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (eeReq && !eeAck) |=> $stable(eeAddr));

  assert_mem_in_burst_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> burstBit);

  assert_burst_clear_on_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burstBit) |-> $past(eeAck));

endmodule

// File: rtl/eeprom_access_engine.sv
module eeprom_access_engine
  import eeacc_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int BASE_W = 9,
  parameter int DEST_W = 24,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [HOST_W-1:0] regWrData,
  output logic [HOST_W-1:0] regRdData,
  output logic              eeReq,
  output logic              eeWrite,
  output logic [EE_AW-1:0]  eeAddr,
  output logic [7:0]        eeWrData,
  input  logic              eeAck,
  input  logic [7:0]        eeRdData,
  output logic              memWrEn,
  output logic [DEST_W-1:0] memAddr,
  output logic [7:0]        memWrData
);

  eeStrobe_t strb;
  logic      active, goWr, goRd, goBurst, lastByte;

  eeacc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .goWr     (goWr),
    .goRd     (goRd),
    .goBurst  (goBurst),
    .eeAck    (eeAck),
    .eeRdData (eeRdData),
    .lastByte (lastByte),
    .strb     (strb),
    .active   (active)
  );

  eeacc_dp #(
    .EE_AW  (EE_AW),
    .BASE_W (BASE_W),
    .DEST_W (DEST_W),
    .HOST_W (HOST_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strb      (strb),
    .active    (active),
    .goWr      (goWr),
    .goRd      (goRd),
    .goBurst   (goBurst),
    .lastByte  (lastByte),
    .eeReq     (eeReq),
    .eeWrite   (eeWrite),
    .eeAddr    (eeAddr),
    .eeWrData  (eeWrData),
    .eeAck     (eeAck),
    .eeRdData  (eeRdData),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

endmodule

// File: tb/eeprom_access_engine_tb.sv
module eeprom_access_engine_tb;

  localparam int EE_AW = 8;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        eeReq, eeWrite;
  logic [EE_AW-1:0] eeAddr;
  logic [7:0]  eeWrData;
  logic        eeAck = 1'b0;
  logic [7:0]  eeRdData = '0;
  logic        memWrEn;
  logic [23:0] memAddr;
  logic [7:0]  memWrData;

  always #2 clk = ~clk;

  eeprom_access_engine #(.EE_AW(EE_AW)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .eeReq(eeReq),
    .eeWrite(eeWrite), .eeAddr(eeAddr), .eeWrData(eeWrData),
    .eeAck(eeAck), .eeRdData(eeRdData), .memWrEn(memWrEn),
    .memAddr(memAddr), .memWrData(memWrData)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0]  eeMem [0:(1<<EE_AW)-1];
  int          accLog[$];
  logic [31:0] expQ[$];

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // EEPROM model: acknowledges each request after LAT waiting cycles
  initial begin
    int waitCnt = 0;
    for (int i = 0; i < (1 << EE_AW); i++) eeMem[i] = 8'h00;
    forever begin
      @(posedge clk);
      if (eeAck) eeAck <= 1'b0;
      else if (eeReq && waitCnt == LAT) begin
        eeAck    <= 1'b1;
        eeRdData <= eeMem[eeAddr];
        if (eeWrite) eeMem[eeAddr] <= eeWrData;
        accLog.push_back(int'(eeAddr));
        waitCnt = 0;
      end else if (eeReq) waitCnt++;
    end
  end

  // scoreboard monitor for the memory port
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memWrEn) begin
        if (expQ.size() == 0) check("R9 unexpected memory write", {memAddr, memWrData}, 0);
        else check("R9 memory write", {memAddr, memWrData}, expQ.pop_front());
      end
    end
  end

  task automatic hostWrite(input logic [2:0] off, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = off; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] off, output logic [31:0] v);
    @(negedge clk);
    regAddr = off;
    #1 v = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      hostRead(3'd0, v);
      if (!v[2]) break;
    end
  endtask

  task automatic expectRec(input logic [8:0] base, input logic [15:0] ra, input logic [7:0] d[]);
    foreach (d[i]) begin
      logic [15:0] a;
      a = ra + 16'(i);
      expQ.push_back({base, a[14:0], d[i]});
    end
  endtask

  task automatic loadBytes(input int at, input logic [7:0] b[]);
    foreach (b[i]) eeMem[(at + i) % (1 << EE_AW)] = b[i];
  endtask

  initial begin
    logic [31:0] v;
    int startIdx;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int o = 0; o < 5; o++) begin
      hostRead(3'(o), v);
      check("R1 register reset", v, 0);
    end
    check("R1 eeReq idle", eeReq, 0);
    check("R1 memWrEn idle", memWrEn, 0);

    // first burst: two records (one with address bit 15 set, one wrapping the 15-bit field), then end
    loadBytes(0, '{8'h81, 8'h23, 8'h03, 8'hAA, 8'hBB, 8'hCC,
                   8'h7F, 8'hFE, 8'h03, 8'h11, 8'h22, 8'h33,
                   8'h00, 8'h00, 8'h00});
    hostWrite(3'd4, 32'h1A5);
    expectRec(9'h1A5, 16'h8123, '{8'hAA, 8'hBB, 8'hCC});
    expectRec(9'h1A5, 16'h7FFE, '{8'h11, 8'h22, 8'h33});
    startIdx = accLog.size();
    hostWrite(3'd3, 32'h1);
    hostRead(3'd3, v);
    check("R5 burst bit set while running", v[0], 1);
    waitIdle();
    hostRead(3'd3, v);
    check("R5 burst bit self-clears", v[0], 0);
    check("R6 first burst starts at 0", accLog[startIdx], 0);
    check("R8 bytes fetched by first burst", accLog.size() - startIdx, 15);
    check("R9 all payload written", expQ.size(), 0);

    // second burst resumes after the terminator
    loadBytes(15, '{8'h00, 8'h05, 8'h01, 8'h5A, 8'h00, 8'h00, 8'h00});
    expectRec(9'h1A5, 16'h0005, '{8'h5A});
    startIdx = accLog.size();
    hostWrite(3'd3, 32'h1);
    waitIdle();
    check("R7 burst resumes after last byte", accLog[startIdx], 15);
    check("R9 second burst payload", expQ.size(), 0);

    // single read, with writes during busy ignored
    eeMem[8'h40] = 8'h9C;
    hostWrite(3'd1, 32'h40);
    hostWrite(3'd0, 32'h2);
    hostRead(3'd0, v);
    check("R4 busy and read bit while reading", v[2:1], 2'b11);
    hostWrite(3'd1, 32'h55);
    hostWrite(3'd3, 32'h1);
    waitIdle();
    hostRead(3'd0, v);
    check("R2 read bit self-clears", v[1:0], 0);
    hostRead(3'd2, v);
    check("R2 read data", v, 32'h9C);
    hostRead(3'd1, v);
    check("R4 address write ignored while busy", v, 32'h40);
    hostRead(3'd3, v);
    check("R4 burst write ignored while busy", v, 0);

    // single write, both bits set: write wins
    hostWrite(3'd2, 32'h3E);
    hostWrite(3'd1, 32'h41);
    hostWrite(3'd0, 32'h3);
    waitIdle();
    check("R3 byte written to EEPROM", eeMem[8'h41], 8'h3E);
    hostRead(3'd0, v);
    check("R3 request bits clear", v, 0);
    hostRead(3'd2, v);
    check("R3 data register unchanged by write", v, 32'h3E);

    // burst after single write resumes at 0x42
    loadBytes(8'h42, '{8'h00, 8'h10, 8'h02, 8'hDE, 8'hAD, 8'h00, 8'h00, 8'h00});
    hostWrite(3'd4, 32'h003);
    expectRec(9'h003, 16'h0010, '{8'hDE, 8'hAD});
    startIdx = accLog.size();
    hostWrite(3'd3, 32'h1);
    waitIdle();
    check("R7 burst after single access", accLog[startIdx], 8'h42);
    check("R9 third burst payload", expQ.size(), 0);

    // pointer wrap across the top of the EEPROM
    hostWrite(3'd1, 32'hFD);
    hostWrite(3'd0, 32'h2);
    waitIdle();
    loadBytes(8'hFE, '{8'h00, 8'h07, 8'h01, 8'h77, 8'h00, 8'h00, 8'h00});
    expectRec(9'h003, 16'h0007, '{8'h77});
    startIdx = accLog.size();
    hostWrite(3'd3, 32'h1);
    waitIdle();
    check("R7 burst starts after single read", accLog[startIdx], 8'hFE);
    check("R7 pointer wraps to 0", accLog[startIdx + 2], 0);
    check("R9 wrapped burst payload", expQ.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule